// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block treats each 32-bit operand as a small vector. It holds either two signed 16-bit lanes or four signed 8-bit lanes, and it adds or subtracts the two vectors lane by lane. A carry or borrow never crosses from one lane into the next. Each width has two modes. In wrapping mode the overflow bits of a lane are dropped. In saturating mode a lane that overflows is clamped to the largest or smallest value its width allows.

The wrapping operations also update four greater-or-equal flags, one for each byte position. A later byte-select operation uses these flags to build a result from bytes of operand A and operand B. This gives a compare-then-merge idiom that needs no branches.

A sticky clipping flag records that a saturating operation clamped at least one lane. It appears in a status word and stays set until software loads it through the status-write port. Software can run a whole block of saturating operations and then test once whether any sample clipped.

The result, the flags and the status word are registered. Each appears one clock after the operation is strobed, together with an output-valid pulse.

Top module: `simd_sat_alu`

## Requirements
- R1: Opcode 0 adds and opcode 1 subtracts two independent signed 16-bit lanes (bits 15:0 and 31:16). Each lane keeps the low 16 bits of its exact result, and no carry or borrow passes between lanes.
- R2: Opcode 4 adds and opcode 5 subtracts four independent signed 8-bit lanes (byte i at bits 8i+7:8i). Each lane keeps the low 8 bits of its exact result.
- R3: Opcode 2 adds and opcode 3 subtracts 16-bit lanes with saturation. A lane above 32767 becomes 0x7FFF, a lane below -32768 becomes 0x8000, and any other lane keeps its exact value.
- R4: Opcode 6 adds and opcode 7 subtracts 8-bit lanes with saturation. A lane clamps to 0x7F or 0x80, and any other lane keeps its exact value.
- R5: The wrapping operations (opcodes 0, 1, 4, 5) load the GE flags. A flag bit is 1 when the exact signed result of its lane is greater than or equal to zero. In halfword mode, the lower lane drives GE[1:0] and the upper lane drives GE[3:2]. In byte mode, byte i drives GE[i].
- R6: Saturating operations, the select operation and unused opcodes leave the GE flags unchanged.
- R7: Opcode 8 (select) forms result byte i from operand A when GE[i] is 1 and from operand B when GE[i] is 0. It uses the flags as they stood before the select operation.
- R8: A saturating operation that clamps at least one lane sets the sticky flag, which is status bit 27. All other status bits read 0.
- R9: The sticky flag stays unchanged through any number of operations that do not clip. Only a status write changes it, and the write loads the flag from `stat_wr_sat`.
- R10: When a clipping operation and a status write that clears the flag occur in the same cycle, the flag ends up set.
- R11: The result, GE flags, status and `out_valid` update on the first rising edge after `in_valid`. `out_valid` is high only in the cycle after a strobed operation. Unused opcodes 9 to 15 give a result of 0. While `in_valid` is low, the result holds its value.
- R12: After reset, the result, GE flags, status word and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A, packed lanes |
| opb | input | 32 | Operand B, packed lanes |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_sat | input | 1 | Value loaded into the sticky flag on a status write |
| out_valid | output | 1 | High for one cycle when the result is fresh |
| result | output | 32 | Registered packed result |
| ge | output | 4 | Per-byte greater-or-equal flags |
| status | output | 32 | Status word, sticky clipping flag at bit 27 |

## Verification
Every effect of a strobed operation or status write is due exactly one rising edge later: the result, `out_valid`, the GE flags and the sticky flag. The bench drives all inputs on the falling edge and releases them one cycle later. It then compares the outputs at that second falling edge, half a period after the edge that loaded them. A bench model advances in the same step, so the select operation and the sticky flag are always checked against the state left by the previous operation. Idle cycles are checked the same way, to confirm that the result and flags hold.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD16  = 4'd0,
    OP_SUB16  = 4'd1,
    OP_QADD16 = 4'd2,
    OP_QSUB16 = 4'd3,
    OP_ADD8   = 4'd4,
    OP_SUB8   = 4'd5,
    OP_QADD8  = 4'd6,
    OP_QSUB8  = 4'd7,
    OP_SEL    = 4'd8
  } simd_op_e;

  localparam int STAT_W       = 32;
  localparam int STAT_SAT_BIT = 27;
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic             sub,
  output logic [DW-1:0]    wrap_o,
  output logic [DW-1:0]    sat_o,
  output logic [DW/LW-1:0] nonneg_o,
  output logic [DW/LW-1:0] clip_o
);
  localparam int NL = DW / LW;

  // exact signed result, one guard bit wider than the lane
  function automatic logic [LW:0] lane_exact(input logic [LW-1:0] x,
                                             input logic [LW-1:0] y,
                                             input logic s);
    logic [LW:0] xe, ye;
    xe = {x[LW-1], x};
    ye = {y[LW-1], y};
    return s ? (xe - ye) : (xe + ye);
  endfunction

  function automatic logic [LW-1:0] lane_clamp(input logic [LW:0] e);
    if (e[LW] != e[LW-1])
      return e[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
    return e[LW-1:0];
  endfunction

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW:0] ex;
    assign ex = lane_exact(a[i*LW +: LW], b[i*LW +: LW], sub);
    assign wrap_o[i*LW +: LW] = ex[LW-1:0];
    assign sat_o[i*LW +: LW]  = lane_clamp(ex);
    assign nonneg_o[i]        = ~ex[LW];
    assign clip_o[i]          = ex[LW] ^ ex[LW-1];
  end
endmodule

// File: rtl/simd_byte_pick.sv
module simd_byte_pick #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW/8-1:0] pick_a,
  output logic [DW-1:0]   y
);
  localparam int NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign y[i*8 +: 8] = pick_a[i] ? a[i*8 +: 8] : b[i*8 +: 8];
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          stat_wr,
  input  logic          stat_wr_sat,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [DW/8-1:0] ge,
  output logic [STAT_W-1:0] status
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  // opcode fields for the arithmetic group
  logic is_arith, is_byte, is_sat, is_sub, is_sel;
  assign is_arith = ~op[3];
  assign is_byte  = op[2];
  assign is_sat   = op[1];
  assign is_sub   = op[0];
  assign is_sel   = (op == OP_SEL);

  logic [DW-1:0] h_wrap, h_sat, b_wrap, b_sat, sel_y;
  logic [NH-1:0] h_nonneg, h_clip;
  logic [NB-1:0] b_nonneg, b_clip;

  simd_lane_addsub #(.DW(DW), .LW(16)) u_half (
    .a(opa), .b(opb), .sub(is_sub),
    .wrap_o(h_wrap), .sat_o(h_sat), .nonneg_o(h_nonneg), .clip_o(h_clip)
  );

  simd_lane_addsub #(.DW(DW), .LW(8)) u_byte (
    .a(opa), .b(opb), .sub(is_sub),
    .wrap_o(b_wrap), .sat_o(b_sat), .nonneg_o(b_nonneg), .clip_o(b_clip)
  );

  logic [NB-1:0] ge_q;

  simd_byte_pick #(.DW(DW)) u_pick (
    .a(opa), .b(opb), .pick_a(ge_q), .y(sel_y)
  );

  // halfword lane j feeds both GE bits of its two bytes
  logic [NB-1:0] ge_from_half;
  for (genvar j = 0; j < NB; j++) begin : g_gehalf
    assign ge_from_half[j] = h_nonneg[j/2];
  end

  // named internal events
  logic          clip_ev;
  logic          ge_load_ev;
  logic [DW-1:0] res_next;

  assign clip_ev    = in_valid & is_arith & is_sat & (is_byte ? (|b_clip) : (|h_clip));
  assign ge_load_ev = in_valid & is_arith & ~is_sat;

  always_comb begin
    res_next = '0;
    if (is_arith) begin
      case ({is_byte, is_sat})
        2'b00:   res_next = h_wrap;
        2'b01:   res_next = h_sat;
        2'b10:   res_next = b_wrap;
        default: res_next = b_sat;
      endcase
    end else if (is_sel) begin
      res_next = sel_y;
    end
  end

  logic          sat_q;
  logic [DW-1:0] res_q;
  logic          vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      ge_q  <= '0;
      sat_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_next;
      if (ge_load_ev) ge_q <= is_byte ? b_nonneg : ge_from_half;
      if (clip_ev)      sat_q <= 1'b1;   // set wins over a write
      else if (stat_wr) sat_q <= stat_wr_sat;
    end
  end

  always_comb begin
    status = '0;
    status[STAT_SAT_BIT] = sat_q;
  end

  assign result    = res_q;
  assign out_valid = vld_q;
  assign ge        = ge_q;

  // ---------------- assertions ----------------
  a_r8_clip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    clip_ev |=> status[STAT_SAT_BIT]);

  a_r8_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~(32'd1 << STAT_SAT_BIT)) == 32'd0);

  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clip_ev && !stat_wr) |=> $stable(status));

  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !clip_ev) |=> (status[STAT_SAT_BIT] == $past(stat_wr_sat)));

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_ev && stat_wr && !stat_wr_sat) |=> status[STAT_SAT_BIT]);

  a_r6_ge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !op[3] && !op[1]) |=> $stable(ge));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r3_clip_is_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_QADD16 && h_clip[0]) |=>
      (result[15:0] == 16'h7FFF || result[15:0] == 16'h8000));
endmodule

// File: tb/test_simd_sat_alu.sv
module test_simd_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opa = 32'd0, opb = 32'd0;
  logic        stat_wr = 1'b0, stat_wr_sat = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  ge;
  logic [31:0] status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_res = '0;
  logic [3:0]  m_ge  = '0;
  bit          m_sat = 0;

  always #10 clk = ~clk;  // 50 MHz

  simd_sat_alu i_simd_sat_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .stat_wr(stat_wr), .stat_wr_sat(stat_wr_sat),
    .out_valid(out_valid), .result(result), .ge(ge), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference model built on integers
  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] gi, output logic [31:0] r,
                       output logic [3:0] g, output bit clip);
    int lw, nl, lo, hi, x, y, s;
    r = '0; g = gi; clip = 0;
    if (o == 4'd8) begin
      for (int i = 0; i < 4; i++)
        r[i*8 +: 8] = gi[i] ? a[i*8 +: 8] : b[i*8 +: 8];
    end else if (o < 4'd8) begin
      lw = o[2] ? 8 : 16;
      nl = 32 / lw;
      hi = (1 <<< (lw - 1)) - 1;
      lo = -(1 <<< (lw - 1));
      for (int i = 0; i < nl; i++) begin
        if (lw == 16) begin
          x = int'($signed(a[i*16 +: 16]));
          y = int'($signed(b[i*16 +: 16]));
        end else begin
          x = int'($signed(a[i*8 +: 8]));
          y = int'($signed(b[i*8 +: 8]));
        end
        s = o[0] ? x - y : x + y;
        if (o[1]) begin
          if (s > hi) begin s = hi; clip = 1; end
          if (s < lo) begin s = lo; clip = 1; end
        end else begin
          if (lw == 16) begin g[2*i] = (s >= 0); g[2*i+1] = (s >= 0); end
          else g[i] = (s >= 0);
        end
        for (int k = 0; k < lw; k++) r[i*lw + k] = s[k];
      end
    end
  endtask

  // one cycle of stimulus, then compare half a period after the loading edge
  task automatic step(input string req, input bit v, input logic [3:0] o,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit we, input bit wv);
    logic [31:0] r; logic [3:0] g; bit c;
    in_valid = v; op = o; opa = a; opb = b; stat_wr = we; stat_wr_sat = wv;
    @(negedge clk);
    in_valid = 0; stat_wr = 0;
    if (v) begin
      model(o, a, b, m_ge, r, g, c);
      m_res = r; m_ge = g;
    end else c = 0;
    if (c) m_sat = 1;
    else if (we) m_sat = wv;
    chk({req, " result"}, result, m_res);
    chk({req, " ge"}, {28'd0, ge}, {28'd0, m_ge});
    chk({req, " status"}, status, {4'd0, m_sat, 27'd0});
    chk({req, " out_valid"}, {31'd0, out_valid}, {31'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [3:0]  o;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 result", result, 32'd0);
    chk("R12 ge", {28'd0, ge}, 32'd0);
    chk("R12 status", status, 32'd0);
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 lane 0 wraps to zero, no carry into lane 1; R5 GE from halves
    step("R1 add16 carry", 1, 4'd0, 32'h0000FFFF, 32'h00000001, 0, 0);
    step("R1 sub16 borrow", 1, 4'd1, 32'h00010000, 32'h00000001, 0, 0);
    step("R5 ge half mixed", 1, 4'd0, 32'h80000005, 32'h00000001, 0, 0);
    // R2 byte wraps
    step("R2 add8 wrap", 1, 4'd4, 32'h7F80FF01, 32'h0180FF01, 0, 0);
    step("R2 sub8", 1, 4'd5, 32'h00108005, 32'h01200106, 0, 0);
    // R7 select with GE from previous op
    step("R7 select", 1, 4'd8, 32'hAABBCCDD, 32'h11223344, 0, 0);
    // R6 saturating op leaves GE alone; R3 clamp high and low
    step("R3 qadd16 clip", 1, 4'd2, 32'h7FFF8000, 32'h0001FFFF, 0, 0);
    step("R9 non-clip keeps", 1, 4'd2, 32'h00010001, 32'h00010001, 0, 0);
    step("R9 idle keeps", 0, 4'd0, 32'h0, 32'h0, 0, 0);
    step("R9 write clears", 0, 4'd0, 32'h0, 32'h0, 1, 0);
    step("R3 qsub16 clip", 1, 4'd3, 32'h80007FFF, 32'h0001FFFF, 0, 0);
    step("R9 write clears 2", 0, 4'd0, 32'h0, 32'h0, 1, 0);
    step("R4 qsub8 clip", 1, 4'd7, 32'h80007F10, 32'h01FF8101, 0, 0);
    step("R10 set beats clear", 1, 4'd6, 32'h7F000000, 32'h01000000, 1, 0);
    step("R9 write sets", 1, 4'd0, 32'h1, 32'h1, 1, 1);
    step("R11 unused op", 1, 4'd11, 32'hFFFFFFFF, 32'h12345678, 1, 0);
    step("R11 idle hold", 0, 4'd3, 32'h7FFF7FFF, 32'h7FFF7FFF, 0, 0);
    step("R6 select keeps ge", 1, 4'd8, 32'h01020304, 32'h05060708, 0, 0);

    for (int n = 0; n < 600; n++) begin
      o = 4'($urandom_range(0, 9));
      a = $urandom; b = $urandom;
      if ($urandom_range(0, 3) == 0) a = ($urandom_range(0, 1) == 1) ? 32'h7F7F7FFF : 32'h80808000;
      if ($urandom_range(0, 3) == 0) b = ($urandom_range(0, 1) == 1) ? 32'h7F7F7F7F : 32'h80808080;
      step("R1-R11 random", $urandom_range(0, 4) != 0, o, a, b,
           $urandom_range(0, 5) == 0, 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule